// File: doc/BRIEF.md
# Radar Frame Byte-Stream Packer

This block turns one processing frame of radar results into a single byte stream for a host link. The stream starts with a fixed nine-byte header and then carries, in a fixed order, any of three optional payload sections: the range profile, the Doppler magnitude map and a dense map of 2-bit detection classes. A single trailer byte closes the frame. Each frame is started by a one-cycle `start` pulse. The block pulls payload data from external result buffers through plain address/data read ports and hands bytes downstream on a valid/ready handshake.

A small 6-bit stream control register selects the sections. Only its low three bits carry meaning. The block copies them when a frame starts, so a write made while a frame is running takes effect from the next frame on. A 16-bit frame counter goes into every header and steps once per finished frame. The bin counts are parameters, so a small build can be used for verification.

The read ports are combinational. Read data must match the address presented in the same cycle. The detection port returns four consecutive cells per read.

Top module: `rfs_packer`

## Requirements
- R1: While reset is high and after it is released, `out_valid` and `busy` are low until a start pulse arrives. The frame counter resets to 0 and the section-enable bits reset to 3'b111.
- R2: The header is nine bytes: 0xAA, then version 0x02, then a flags byte, then the frame number, then RANGE_BINS, then DOPPLER_BINS. The last three fields are each 16 bits and are sent high byte first.
- R3: When enable bit 0 is set, the range section follows the header. It holds RANGE_BINS 16-bit words, high byte first, read from `rng_addr` = 0,1,2,... in ascending order.
- R4: When enable bit 1 is set, the Doppler section comes next. It holds RANGE_BINS*DOPPLER_BINS 16-bit words, high byte first, read from `dop_addr` in ascending cell order, which is the buffer's row-major order.
- R5: When enable bit 2 is set, the detection section comes next. It holds ceil(CELLS/4) bytes. Byte j holds cells 4j..4j+3, and cell 4j+k sits in bits [7-2k -: 2]. The port returns cell 4*`det_addr`+k on `det_rdata[2k+1:2k]`. Cells at or beyond CELLS are sent as 00.
- R6: Every frame ends with one byte 0x55 that has `out_last` high. In the cycle after that byte is accepted, `out_valid` and `busy` are low.
- R7: A write to the stream control register loads enable bits [2:0] from `ctrl_wdata[2:0]` and ignores `ctrl_wdata[5:3]`. The header flags byte is {5'b0, bit2, bit1, bit0}. The enable bits are captured at frame start, so a write made during a frame has no effect on that frame.
- R8: The frame number in the header starts at 0 and rises by one, modulo 2^16, each time a trailer byte is accepted.
- R9: The stream advances by one byte only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, the offered byte is held. No byte is dropped or repeated.
- R10: A start pulse while idle makes the first header byte valid in the next cycle. A start pulse while a frame is in progress is ignored and does not begin another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse |
| ctrl_wr | input | 1 | Stream control write strobe |
| ctrl_wdata | input | 6 | Stream control write data; bits [2:0] enable range, Doppler, detection |
| rng_addr | output | RAW | Range profile read address |
| rng_rdata | input | 16 | Range profile word at `rng_addr` |
| dop_addr | output | DAW | Doppler map read address (cell index) |
| dop_rdata | input | 16 | Doppler magnitude at `dop_addr` |
| det_addr | output | TAW | Detection read address (group of four cells) |
| det_rdata | input | 8 | Four 2-bit classes, cell 4*addr+k in bits [2k+1:2k] |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_last | output | 1 | Byte is the frame trailer |
| busy | output | 1 | Frame in progress |

## Verification
The first header byte is due one cycle after the clock edge that samples `start`. After that, each byte is due in the cycle after the edge that accepted the previous one. `busy` and `out_valid` drop one cycle after the trailer is accepted. The bench drives `start`, `out_ready` and control writes on the falling edge and samples 1 ns later. It records a byte only in a cycle where it has itself raised `out_ready` while `out_valid` is high, so every comparison is made in the cycle the byte is consumed. Enable writes are checked against the header of the following frame. A write made in mid-frame is checked against both the frame in progress and the next frame.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HEAD  = 3'd1,
        S_RANGE = 3'd2,
        S_DOPP  = 3'd3,
        S_DET   = 3'd4,
        S_TAIL  = 3'd5
    } sect_e;

    typedef struct packed {
        logic det;
        logic dop;
        logic rng;
    } flags_t;

    localparam logic [7:0] SYNC_BYTE    = 8'hAA;
    localparam logic [7:0] VERSION_BYTE = 8'h02;
    localparam logic [7:0] TAIL_BYTE    = 8'h55;
    localparam int         HEAD_LEN     = 9;
    localparam logic [2:0] FLAGS_RST    = 3'b111;

    function automatic int awidth(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [7:0] word_byte(input logic [15:0] w, input logic low);
        return low ? w[7:0] : w[15:8];
    endfunction

    // Section that follows cur, skipping disabled payload sections.
    function automatic sect_e next_sect(input sect_e cur, input flags_t f);
        sect_e n;
        case (cur)
            S_HEAD:  n = f.rng ? S_RANGE : (f.dop ? S_DOPP : (f.det ? S_DET : S_TAIL));
            S_RANGE: n = f.dop ? S_DOPP : (f.det ? S_DET : S_TAIL);
            S_DOPP:  n = f.det ? S_DET : S_TAIL;
            S_DET:   n = S_TAIL;
            default: n = S_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rfs_ctrl.sv
`timescale 1ns/1ps
module rfs_ctrl
    import rfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  wr_data,
    input  logic        frame_done,
    output flags_t      flags,
    output logic [15:0] frame_num
);

    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[5:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= flags_t'(FLAGS_RST);
        end else if (wr_en) begin
            flags <= flags_t'(wr_data[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_num <= '0;
        end else if (frame_done) begin
            frame_num <= frame_num + 16'd1;
        end
    end

    p_flags_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flags == flags_t'($past(wr_data[2:0]))));

    p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (frame_num == $past(frame_num) + 16'd1));

    p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(frame_num));

endmodule

// File: rtl/rfs_seq.sv
`timescale 1ns/1ps
module rfs_seq
    import rfs_pkg::*;
#(
    parameter int RANGE_BINS = 512,
    parameter int CELLS      = 512 * 48,
    parameter int DET_BYTES  = (512 * 48 + 3) / 4,
    parameter int CW         = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          ready,
    input  flags_t        live_flags,
    output sect_e         sect,
    output logic [CW-1:0] idx,
    output flags_t        cur_flags,
    output logic          valid,
    output logic          frame_done
);

    localparam logic [CW-1:0] HEAD_N = CW'(HEAD_LEN);
    localparam logic [CW-1:0] RNG_N  = CW'(2 * RANGE_BINS);
    localparam logic [CW-1:0] DOP_N  = CW'(2 * CELLS);
    localparam logic [CW-1:0] DET_N  = CW'(DET_BYTES);
    localparam logic [CW-1:0] TAIL_N = CW'(1);

    logic [CW-1:0] sect_len;
    logic          fire;
    logic          at_end;

    always_comb begin
        case (sect)
            S_HEAD:  sect_len = HEAD_N;
            S_RANGE: sect_len = RNG_N;
            S_DOPP:  sect_len = DOP_N;
            S_DET:   sect_len = DET_N;
            default: sect_len = TAIL_N;
        endcase
    end

    assign valid      = (sect != S_IDLE);
    assign fire       = valid && ready;
    assign at_end     = (idx == sect_len - TAIL_N);
    assign frame_done = fire && (sect == S_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sect      <= S_IDLE;
            idx       <= '0;
            cur_flags <= '0;
        end else if (sect == S_IDLE) begin
            if (start) begin
                sect      <= S_HEAD;
                idx       <= '0;
                cur_flags <= live_flags;
            end
        end else if (fire) begin
            if (at_end) begin
                sect <= next_sect(sect, cur_flags);
                idx  <= '0;
            end else begin
                idx <= idx + TAIL_N;
            end
        end
    end

    p_start_head_r10: assert property (@(posedge clk) disable iff (rst)
        (sect == S_IDLE && start) |=> (sect == S_HEAD && idx == '0));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && !frame_done && !(sect == S_HEAD && idx == '0))
            |=> !(sect == S_HEAD && idx == '0));

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> ($stable(sect) && $stable(idx)));

    p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
        valid |-> (idx < sect_len));

    p_tail_idle_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (sect == S_IDLE));

endmodule

// File: rtl/rfs_bytes.sv
`timescale 1ns/1ps
module rfs_bytes
    import rfs_pkg::*;
#(
    parameter int RANGE_BINS   = 512,
    parameter int DOPPLER_BINS = 48,
    parameter int CELLS        = 512 * 48,
    parameter int CW           = 16,
    parameter int RAW          = 9,
    parameter int DAW          = 15,
    parameter int TAW          = 13
) (
    input  sect_e          sect,
    input  logic [CW-1:0]  idx,
    input  flags_t         cur_flags,
    input  logic [15:0]    frame_num,
    input  logic [15:0]    rng_rdata,
    input  logic [15:0]    dop_rdata,
    input  logic [7:0]     det_rdata,
    output logic [RAW-1:0] rng_addr,
    output logic [DAW-1:0] dop_addr,
    output logic [TAW-1:0] det_addr,
    output logic [7:0]     out_byte
);

    localparam logic [15:0] RB_FIELD = 16'(RANGE_BINS);
    localparam logic [15:0] DB_FIELD = 16'(DOPPLER_BINS);
    localparam int          LANES    = 4;

    logic [3:0]    hsel;
    logic [7:0]    head_byte;
    logic [7:0]    det_byte;
    logic [CW+1:0] cell_base;

    assign rng_addr  = RAW'(idx >> 1);
    assign dop_addr  = DAW'(idx >> 1);
    assign det_addr  = TAW'(idx);
    assign hsel      = 4'(idx);
    assign cell_base = {idx, 2'b00};

    always_comb begin
        case (hsel)
            4'd0:    head_byte = SYNC_BYTE;
            4'd1:    head_byte = VERSION_BYTE;
            4'd2:    head_byte = {5'b0, cur_flags};
            4'd3:    head_byte = frame_num[15:8];
            4'd4:    head_byte = frame_num[7:0];
            4'd5:    head_byte = RB_FIELD[15:8];
            4'd6:    head_byte = RB_FIELD[7:0];
            4'd7:    head_byte = DB_FIELD[15:8];
            default: head_byte = DB_FIELD[7:0];
        endcase
    end

    // Lane k of the read port is cell 4j+k; it is sent in bits [7-2k -: 2].
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic in_range;
        assign in_range = (32'(cell_base) + k) < CELLS;
        assign det_byte[7-2*k -: 2] = in_range ? det_rdata[2*k +: 2] : 2'b00;
    end

    always_comb begin
        case (sect)
            S_HEAD:  out_byte = head_byte;
            S_RANGE: out_byte = word_byte(rng_rdata, idx[0]);
            S_DOPP:  out_byte = word_byte(dop_rdata, idx[0]);
            S_DET:   out_byte = det_byte;
            S_TAIL:  out_byte = TAIL_BYTE;
            default: out_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/rfs_packer.sv
`timescale 1ns/1ps
module rfs_packer
    import rfs_pkg::*;
#(
    parameter  int RANGE_BINS   = 512,
    parameter  int DOPPLER_BINS = 48,
    localparam int CELLS        = RANGE_BINS * DOPPLER_BINS,
    localparam int DET_BYTES    = (CELLS + 3) / 4,
    localparam int RAW          = awidth(RANGE_BINS),
    localparam int DAW          = awidth(CELLS),
    localparam int TAW          = awidth(DET_BYTES),
    localparam int MAXLEN       = imax(imax(2 * CELLS, 2 * RANGE_BINS), imax(DET_BYTES, HEAD_LEN)),
    localparam int CW           = $clog2(MAXLEN + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           ctrl_wr,
    input  logic [5:0]     ctrl_wdata,
    output logic [RAW-1:0] rng_addr,
    input  logic [15:0]    rng_rdata,
    output logic [DAW-1:0] dop_addr,
    input  logic [15:0]    dop_rdata,
    output logic [TAW-1:0] det_addr,
    input  logic [7:0]     det_rdata,
    output logic [7:0]     out_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic           out_last,
    output logic           busy
);

    flags_t        live_flags;
    flags_t        cur_flags;
    logic [15:0]   frame_num;
    sect_e         sect;
    logic [CW-1:0] idx;
    logic          valid;
    logic          frame_done;

    rfs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctrl_wr),
        .wr_data    (ctrl_wdata),
        .frame_done (frame_done),
        .flags      (live_flags),
        .frame_num  (frame_num)
    );

    rfs_seq #(
        .RANGE_BINS (RANGE_BINS),
        .CELLS      (CELLS),
        .DET_BYTES  (DET_BYTES),
        .CW         (CW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ready      (out_ready),
        .live_flags (live_flags),
        .sect       (sect),
        .idx        (idx),
        .cur_flags  (cur_flags),
        .valid      (valid),
        .frame_done (frame_done)
    );

    rfs_bytes #(
        .RANGE_BINS   (RANGE_BINS),
        .DOPPLER_BINS (DOPPLER_BINS),
        .CELLS        (CELLS),
        .CW           (CW),
        .RAW          (RAW),
        .DAW          (DAW),
        .TAW          (TAW)
    ) u_bytes (
        .sect      (sect),
        .idx       (idx),
        .cur_flags (cur_flags),
        .frame_num (frame_num),
        .rng_rdata (rng_rdata),
        .dop_rdata (dop_rdata),
        .det_rdata (det_rdata),
        .rng_addr  (rng_addr),
        .dop_addr  (dop_addr),
        .det_addr  (det_addr),
        .out_byte  (out_data)
    );

    assign out_valid = valid;
    assign busy      = valid;
    assign out_last  = (sect == S_TAIL);

    p_last_is_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (out_data == 8'h55));

endmodule

// File: tb/rfs_packer_bench.sv
`timescale 1ns/1ps
module rfs_packer_bench;

    localparam int RB  = 5;
    localparam int DB  = 2;
    localparam int NC  = RB * DB;
    localparam int NDB = (NC + 3) / 4;
    localparam int RAW = (RB > 1) ? $clog2(RB) : 1;
    localparam int DAW = (NC > 1) ? $clog2(NC) : 1;
    localparam int TAW = (NDB > 1) ? $clog2(NDB) : 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           ctrl_wr = 1'b0;
    logic [5:0]     ctrl_wdata = '0;
    logic [RAW-1:0] rng_addr;
    logic [15:0]    rng_rdata;
    logic [DAW-1:0] dop_addr;
    logic [15:0]    dop_rdata;
    logic [TAW-1:0] det_addr;
    logic [7:0]     det_rdata;
    logic [7:0]     out_data;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic           out_last;
    logic           busy;

    int          vectors = 0;
    int          errors  = 0;
    logic [15:0] fnum    = 16'd0;
    logic [7:0]  exp_b [0:63];
    string       exp_t [0:63];
    int          exp_n;

    always #10 clk = ~clk;

    rfs_packer #(.RANGE_BINS(RB), .DOPPLER_BINS(DB)) u_rfs_packer (
        .clk(clk), .rst(rst), .start(start), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .rng_addr(rng_addr), .rng_rdata(rng_rdata), .dop_addr(dop_addr), .dop_rdata(dop_rdata),
        .det_addr(det_addr), .det_rdata(det_rdata), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_last(out_last), .busy(busy)
    );

    function automatic logic [15:0] rng_word(input int a);
        return 16'hA000 ^ 16'(a * 291);
    endfunction

    function automatic logic [15:0] dop_word(input int c);
        return 16'h5003 + 16'(c * 257);
    endfunction

    function automatic logic [1:0] det_cls(input int c);
        return 2'((c * 3 + 1) % 4);
    endfunction

    // Buffer models: combinational reads, including cells past the end.
    always_comb begin
        rng_rdata = rng_word(int'(rng_addr));
        dop_rdata = dop_word(int'(dop_addr));
        for (int k = 0; k < 4; k++) det_rdata[2*k +: 2] = det_cls(int'(det_addr) * 4 + k);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        exp_b[exp_n] = b;
        exp_t[exp_n] = tag;
        exp_n++;
    endtask

    task automatic build(input logic [2:0] f, input logic [15:0] fn);
        exp_n = 0;
        push(8'hAA, "R2"); push(8'h02, "R2"); push({5'b0, f}, "R7");
        push(fn[15:8], "R8"); push(fn[7:0], "R8");
        push(8'(RB >> 8), "R2"); push(8'(RB), "R2");
        push(8'(DB >> 8), "R2"); push(8'(DB), "R2");
        if (f[0]) for (int a = 0; a < RB; a++) begin
            push(rng_word(a)[15:8], "R3"); push(rng_word(a)[7:0], "R3");
        end
        if (f[1]) for (int c = 0; c < NC; c++) begin
            push(dop_word(c)[15:8], "R4"); push(dop_word(c)[7:0], "R4");
        end
        if (f[2]) for (int j = 0; j < NDB; j++) begin
            logic [7:0] b;
            b = 8'h00;
            for (int k = 0; k < 4; k++)
                if (4 * j + k < NC) b[7 - 2*k -: 2] = det_cls(4 * j + k);
            push(b, "R5");
        end
        push(8'h55, "R6");
    endtask

    function automatic bit rdy(input int pat, input int g);
        case (pat)
            0:       return 1'b1;
            1:       return (g % 2) == 0;
            2:       return (g % 3) != 1;
            default: return (g % 4) == 3;
        endcase
    endfunction

    task automatic write_ctrl(input logic [5:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic run_frame(input logic [2:0] f, input int pat, input bit inj,
                             input int inj_at, input logic [5:0] inj_w);
        logic [7:0] got [0:63];
        int   n = 0;
        int   g = 0;
        bit   held = 1'b0;
        bit   injd = 1'b0;
        logic [7:0] held_b = 8'h00;
        build(f, fnum);
        @(negedge clk);
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        while (n < exp_n && g < 4000) begin
            out_ready = rdy(pat, g);
            if (inj && !injd && n >= inj_at) begin
                start = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = inj_w; injd = 1'b1;
            end else begin
                start = 1'b0; ctrl_wr = 1'b0;
            end
            #1;
            if (g == 0) check(out_valid === 1'b1, "R10 first byte timing", 32'(out_valid), 1);
            if (out_valid) begin
                if (held) check(out_data == held_b, "R9 stall hold", out_data, held_b);
                if (out_ready) begin
                    got[n] = out_data; n++; held = 1'b0;
                end else begin
                    held = 1'b1; held_b = out_data;
                end
            end
            g++;
            @(negedge clk);
        end
        start = 1'b0; ctrl_wr = 1'b0; out_ready = 1'b0;
        #1;
        check(!out_valid && !busy, "R6 idle after trailer", {busy, out_valid}, 0);
        check(n == exp_n, "R9 byte count", n, exp_n);
        for (int i = 0; i < exp_n; i++)
            if (i < n) check(got[i] == exp_b[i], exp_t[i], got[i], exp_b[i]);
        fnum = fnum + 16'd1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !busy, "R1 in reset", {busy, out_valid}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(!out_valid && !busy, "R1 after reset", {busy, out_valid}, 0);
        // R1: reset flags 111 and frame number 0 appear in the first header
        run_frame(3'b111, 0, 1'b0, 0, 6'd0);

        // R3 R4 R5 R7: all enable combinations, reserved bits written as 101
        for (int f = 0; f < 8; f++) begin
            write_ctrl({3'b101, 3'(f)});
            run_frame(3'(f), f % 4, 1'b0, 0, 6'd0);
            run_frame(3'(f), 3 - (f % 4), 1'b0, 0, 6'd0);
        end

        // R10 R7: start and control write in mid-frame
        write_ctrl(6'b000111);
        run_frame(3'b111, 1, 1'b1, 12, 6'b111010);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check(!out_valid && !busy, "R10 start ignored while busy", {busy, out_valid}, 0);
        end
        // R7 R8: next frame uses the new flags and the next frame number
        run_frame(3'b010, 2, 1'b0, 0, 6'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule